// File: doc/BRIEF.md
# Byte-Mode DRAM Access Sequencer

This block performs one byte access to a page-mode DRAM each time an arbiter grants it. A one-clock start strobe picks the kind of cycle, which is a read, a write or a refresh. The block then runs a fixed five-clock pattern on the DRAM pins. It splits the byte address into a row part and a column part and places them on a shared address bus. It drives the row strobe, column strobe, output enable and write enable. On a read, it captures the returned byte near the end of the cycle.

A two-bit capacity input selects the buffer size: 256 KB, 1 MB or 4 MB. This setting decides how many address bits go to the row half and how many to the column half. A refresh request runs a column-before-row cycle. This cycle leaves the address bus at zero and also takes five clocks. Arbitration and burst policy belong to the logic that drives the start strobe.

Top module: `dram_byte_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start, ras_n, cas_n, oe_n and we_n are 1, busy, done and dq_oe are 0, and rdata is 0.
- R2: In the first clock after a read or write start is sampled at a rising edge, ras_n is 0, cas_n is 1 and mem_addr carries the row part of the address.
- R3: In the second clock of a read or write, mem_addr carries the column part, ras_n stays 0 and cas_n is still 1.
- R4: In clocks three and four of a read, cas_n and oe_n are 0, we_n is 1 and dq_oe is 0. At the end of clock four, rdata takes dq_in and holds it until the next read.
- R5: In clocks three and four of a write, cas_n and we_n are 0, oe_n is 1, dq_oe is 1 and dq_out carries the byte given at start.
- R6: Every access keeps busy high for exactly five clocks. In the fifth clock all strobes are 1, mem_addr is 0 and done is 1 for that single clock.
- R7: Capacity code 0 splits the address into 9 column bits (addr[8:0]) and 9 row bits (addr[17:9]). Code 1 gives 10 and 10 bits. Codes 2 and 3 give 11 and 11 bits. The higher mem_addr pins that are not used read 0.
- R8: A refresh holds cas_n low in clocks one to four and ras_n low in clocks two to four. It keeps oe_n, we_n high, dq_oe low and mem_addr at 0, and leaves rdata unchanged.
- R9: A start while busy is ignored. The address, data, kind and capacity are captured at the accepting edge, so later changes to those inputs have no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Access request strobe, sampled only while idle |
| do_refresh | input | 1 | With start: run a refresh cycle |
| do_write | input | 1 | With start: write (1) or read (0) |
| cap_sel | input | 2 | Capacity code: 0=256 KB, 1=1 MB, 2/3=4 MB |
| addr | input | 22 | Byte address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | High in the last clock of an access |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 11 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| we_n | output | 1 | DRAM write enable, active low |
| dq_out | output | 8 | Data driven to DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Data returned by DRAM |

## Verification
The bench runs reads and writes under every capacity code. It uses addresses whose set bits sit on both sides of each split point, so a wrong split shows up as a wrong row or column. It also uses addresses with every bit set, so a missing mask shows up on the unused pins. A refresh that falls between two reads tells a refresh cycle apart from a read, through the strobe order and through the rdata value that must be kept. A start held high for many clocks, and address changes in the middle of an access, show whether the block ignores starts while busy and whether it latches its inputs at the accepting edge. dq_in changes every clock, so rdata also shows which clock does the latching.

// File: rtl/dram_byte_seq.sv
module dram_byte_seq #(
  parameter int MA_W   = 11,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * MA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              do_refresh,
  input  logic              do_write,
  input  logic [1:0]        cap_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [MA_W-1:0]   mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  logic [2:0]        phase, nxt;
  logic              ref_q, wr_q;
  logic [1:0]        cap_q;
  logic [ADDR_W-1:0] addr_q;

  wire go = start && (phase == 3'd0);
  wire              use_ref  = go ? do_refresh : ref_q;
  wire              use_wr   = go ? do_write   : wr_q;
  wire [1:0]        use_cap  = go ? cap_sel    : cap_q;
  wire [ADDR_W-1:0] use_addr = go ? addr       : addr_q;

  function automatic logic [MA_W-1:0] pick(input logic [ADDR_W-1:0] a,
                                           input logic [1:0] c, input logic row);
    int n;
    logic [MA_W-1:0]   m;
    logic [ADDR_W-1:0] s;
    case (c)
      2'd0:    n = MA_W - 2;
      2'd1:    n = MA_W - 1;
      default: n = MA_W;
    endcase
    m = MA_W'((64'd1 << n) - 64'd1);
    s = row ? (a >> n) : a;
    return s[MA_W-1:0] & m;
  endfunction

  always_comb begin
    if (go)                 nxt = 3'd1;
    else if (phase == 3'd5) nxt = 3'd0;
    else if (phase != 3'd0) nxt = phase + 3'd1;
    else                    nxt = 3'd0;
  end

  wire n_open = (nxt >= 3'd1) && (nxt <= 3'd4);
  wire n_row  = (nxt >= 3'd2) && (nxt <= 3'd4);
  wire n_cas  = (nxt == 3'd3) || (nxt == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      ref_q    <= 1'b0;
      wr_q     <= 1'b0;
      cap_q    <= '0;
      addr_q   <= '0;
      dq_out   <= '0;
      rdata    <= '0;
      mem_addr <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase <= nxt;
      if (go) begin
        ref_q  <= do_refresh;
        wr_q   <= do_write;
        cap_q  <= cap_sel;
        addr_q <= addr;
        dq_out <= wdata;
      end
      if (phase == 3'd4 && !ref_q && !wr_q) rdata <= dq_in;
      ras_n <= !(use_ref ? n_row : n_open);
      cas_n <= !(use_ref ? n_open : n_cas);
      oe_n  <= !(!use_ref && !use_wr && n_cas);
      we_n  <= !(!use_ref && use_wr && n_cas);
      dq_oe <= !use_ref && use_wr && n_cas;
      done  <= (nxt == 3'd5);
      if (use_ref || nxt == 3'd0 || nxt == 3'd5) mem_addr <= '0;
      else if (nxt == 3'd1)                      mem_addr <= pick(use_addr, use_cap, 1'b1);
      else                                       mem_addr <= pick(use_addr, use_cap, 1'b0);
    end
  end

  assign busy = (phase != 3'd0);

  p_cas_after_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ref_q) |-> (!ras_n && $past(!ras_n)));
  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || we_n));
  p_drive_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !cas_n));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n && cas_n && oe_n && we_n && busy));
  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && ref_q) |-> (!cas_n && $past(!cas_n) && mem_addr == '0));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(ref_q) && $stable(addr_q)));

endmodule

// File: tb/tb_dram_byte_seq.sv
`timescale 1ns/1ps
module tb_dram_byte_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, do_refresh = 0, do_write = 0;
  logic [1:0] cap_sel = 0;
  logic [21:0] addr = 0;
  logic [7:0] wdata = 0, dq_in = 0;
  logic busy, done, ras_n, cas_n, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_out;
  logic [10:0] mem_addr;
  int checks = 0, failures = 0;

  dram_byte_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .do_refresh(do_refresh),
    .do_write(do_write), .cap_sel(cap_sel), .addr(addr), .wdata(wdata), .busy(busy),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n),
    .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #2 clk = ~clk;

  int ph = 0; bit m_ref, m_wr; int m_cap; int m_addr; int m_data; int m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin ph = 0; m_rd = 0; end
    else begin
      if (ph == 4 && !m_ref && !m_wr) m_rd = dq_in;
      if (ph == 0 && start) begin
        ph = 1; m_ref = do_refresh; m_wr = do_write; m_cap = cap_sel;
        m_addr = addr; m_data = wdata;
      end else if (ph == 5) ph = 0;
      else if (ph != 0) ph = ph + 1;
    end
  end

  function automatic int half(int a, int cap, bit row);
    int n = (cap == 0) ? 9 : (cap == 1) ? 10 : 11;
    int v = row ? (a / (1 << n)) : a;
    return v % (1 << n);
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h phase=%0d t=%0t", r, what, act, exp, ph, $time);
    end
  endtask

  always @(negedge clk) begin
    string r;
    int e_ras, e_cas, e_oe, e_we, e_dqoe, e_addr;
    if (!rst_n) r = "R1";
    else if (ph == 0) r = "R9";
    else if (m_ref) r = "R8";
    else if (ph == 1) r = "R2";
    else if (ph == 2) r = "R3";
    else if (ph == 5) r = "R6";
    else r = m_wr ? "R5" : "R4";
    e_ras = !((!m_ref && ph >= 1 && ph <= 4) || (m_ref && ph >= 2 && ph <= 4));
    e_cas = !((!m_ref && ph >= 3 && ph <= 4) || (m_ref && ph >= 1 && ph <= 4));
    e_oe  = !(!m_ref && !m_wr && ph >= 3 && ph <= 4);
    e_we  = !(!m_ref && m_wr && ph >= 3 && ph <= 4);
    e_dqoe = !e_we;
    if (ph == 0 || ph == 5 || m_ref) e_addr = 0;
    else e_addr = half(m_addr, m_cap, ph == 1);
    if (ph == 0) begin e_ras = 1; e_cas = 1; e_oe = 1; e_we = 1; e_dqoe = 0; end
    chk(r, "ras_n", ras_n, e_ras);
    chk(r, "cas_n", cas_n, e_cas);
    chk(r, "oe_n", oe_n, e_oe);
    chk(r, "we_n", we_n, e_we);
    chk(r, "dq_oe", dq_oe, e_dqoe);
    chk((ph == 1 || ph == 2) && !m_ref ? "R7" : r, "mem_addr", mem_addr, e_addr);
    chk(r == "R6" ? r : "R6", "busy", busy, ph != 0);
    chk("R6", "done", done, ph == 5);
    chk(m_ref ? "R8" : "R4", "rdata", rdata, m_rd);
    if (dq_oe && e_dqoe) chk("R5", "dq_out", dq_out, m_data);
    dq_in <= dq_in * 8'd5 + 8'd37;
  end

  task automatic op(bit rf, bit wr, int a, int d, int cap);
    @(negedge clk);
    start = 1; do_refresh = rf; do_write = wr; addr = 22'(a); wdata = 8'(d); cap_sel = 2'(cap);
    @(negedge clk);
    start = 0; addr = ~addr; wdata = ~wdata; do_write = ~do_write; cap_sel = ~cap_sel;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    op(0, 0, 22'h0003FF, 0, 0);
    op(0, 1, 22'h0AB5A5, 8'hC3, 1);
    op(0, 0, 22'h3FFFFF, 0, 2);
    op(0, 1, 22'h200401, 8'h5A, 3);
    op(0, 0, 22'h3FFFFF, 0, 0);
    op(1, 0, 22'h3FFFFF, 0, 2);
    op(0, 0, 22'h155555, 0, 1);
    op(1, 1, 22'h2AAAAA, 8'hFF, 0);
    @(negedge clk);
    start = 1; do_write = 1; addr = 22'h123456; wdata = 8'h77; cap_sel = 2;
    repeat (14) @(negedge clk);
    start = 0;
    repeat (8) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule